// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source side of a two-level interrupt controller. It holds state for a parameterized set of interrupt sources. Each source is fixed at build time as level-sensitive or message-style, and each carries a target server number, a priority and four status flags: asserted, sent, rejected and masked-pending. Input events, configuration writes and notifications from the presentation layer all arrive on one command channel, one command per accepted cycle. When a source has to be presented, the block raises a request that carries the source's global number, server and priority. It holds that request until the presentation layer acknowledges it.

A source's global number is its index plus the parameter `BASE`. The presentation layer returns reject and end-of-interrupt (EOI) notifications by global number. It can also ask for a resend, which makes the block walk all sources in ascending index order, one source per cycle. During a resend walk, and while a request waits for acknowledgement, the command channel is stalled. No command is ever lost. The presentation layer must acknowledge a request before it issues the matching reject.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset there is no request pending, `cmd_ready` is high, every priority is 0xFF (masked) and every status flag is clear. The level or message type of each source, taken from `LVL_MAP` (bit i set means source i is level), is unchanged by reset.
- R2: Command codes on `cmd_op` are 0 event, 1 write, 2 reject, 3 EOI and 4 resend. An event with `cmd_val`=1 on an unmasked message source makes `req_valid` high in the next cycle, with `req_num` equal to the index plus `BASE`, together with that source's server and priority.
- R3: An event on a masked message source gives no request and sets masked-pending. A later write with a priority other than 0xFF clears the flag and presents the source once, with the newly written server and priority. A second such write presents nothing.
- R4: An event on a level source copies `cmd_val` into its asserted flag. The source presents only when it is unmasked, asserted and not already sent, and presenting sets sent. Further events while sent give no request.
- R5: A reject sets the rejected flag of a message source and clears the sent flag of a level source. A following resend presents both again.
- R6: An EOI clears the sent flag of a level source, so a still-asserted source presents again on its next event or resend. On a message source an EOI changes nothing.
- R7: A write to a level source stores the server and priority and then applies the level presentation check.
- R8: A resend visits the sources in ascending index order, one per cycle. It presents rejected, unmasked message sources (and clears their rejected flag) and eligible level sources, and waits for each acknowledgement before it continues. `cmd_ready` stays low during the walk and while a request is pending.
- R9: Commands whose number falls outside `BASE` to `BASE+NSRC-1` change no state and produce no request.
- R10: While `req_valid` is high and `req_ack` is low, the request fields stay stable. `req_valid` drops in the cycle after an acknowledgement.
- R11: A source with priority 0xFF is never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_num | input | NUMW | Global interrupt number |
| cmd_val | input | 1 | Event level or trigger |
| cmd_server | input | SRVW | Server for a write |
| cmd_prio | input | PRIW | Priority for a write |
| req_valid | output | 1 | Presentation request pending |
| req_ack | input | 1 | Presentation layer took the request |
| req_num | output | NUMW | Global number of presented source |
| req_server | output | SRVW | Target server |
| req_prio | output | PRIW | Priority |

## Verification
The hardest state to reach is a resend that finds several sources in different conditions at once. It needs rejected message sources, a level source whose sent flag was cleared by a reject while it is still asserted, and a message source that received an EOI that must not disturb it. The stimulus builds this state by presenting, acknowledging and rejecting each source in turn before it issues the resend. It then follows the walk request by request, holding off one acknowledgement to watch the request stay stable. A second resend and an EOI-driven resend confirm that the flags were consumed as required.

// File: rtl/irq_source_ctl.sv
module irq_source_ctl #(
  parameter int NSRC = 8,
  parameter int BASE = 16,
  parameter int NUMW = 8,
  parameter int SRVW = 4,
  parameter int PRIW = 8,
  parameter logic [NSRC-1:0] LVL_MAP = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [NUMW-1:0] cmd_num,
  input  logic            cmd_val,
  input  logic [SRVW-1:0] cmd_server,
  input  logic [PRIW-1:0] cmd_prio,
  output logic            req_valid,
  input  logic            req_ack,
  output logic [NUMW-1:0] req_num,
  output logic [SRVW-1:0] req_server,
  output logic [PRIW-1:0] req_prio
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [PRIW-1:0] MASKED = {PRIW{1'b1}};
  localparam logic [2:0] OP_EVENT = 3'd0, OP_WRITE = 3'd1, OP_REJECT = 3'd2,
                         OP_EOI = 3'd3, OP_RESEND = 3'd4;

  logic [SRVW-1:0] srv_q [NSRC];
  logic [PRIW-1:0] pri_q [NSRC];
  logic [NSRC-1:0] asrt_q, sent_q, rej_q, mpend_q;
  logic            scan_q;
  logic [IW-1:0]   scan_idx;

  logic [NUMW-1:0] off;
  logic            in_rng, take, scan_step, cur_lvl, unmasked, fire;
  logic [IW-1:0]   cur;
  logic [SRVW-1:0] f_srv;
  logic [PRIW-1:0] f_pri;

  assign off       = cmd_num - NUMW'(BASE);
  assign in_rng    = off < NUMW'(NSRC);
  assign cmd_ready = !req_valid && !scan_q;
  assign take      = cmd_valid && cmd_ready;
  assign scan_step = scan_q && !req_valid;
  assign cur       = scan_q ? scan_idx : off[IW-1:0];
  assign cur_lvl   = LVL_MAP[cur];
  assign unmasked  = pri_q[cur] != MASKED;

  always_comb begin
    fire  = 1'b0;
    f_srv = srv_q[cur];
    f_pri = pri_q[cur];
    if (scan_step) begin
      if (cur_lvl) fire = unmasked && asrt_q[cur] && !sent_q[cur];
      else         fire = unmasked && rej_q[cur];
    end else if (take && in_rng) begin
      if (cmd_op == OP_EVENT) begin
        if (cur_lvl) fire = cmd_val && unmasked && !sent_q[cur];
        else         fire = cmd_val && unmasked;
      end else if (cmd_op == OP_WRITE) begin
        f_srv = cmd_server;
        f_pri = cmd_prio;
        if (cur_lvl) fire = (cmd_prio != MASKED) && asrt_q[cur] && !sent_q[cur];
        else         fire = (cmd_prio != MASKED) && mpend_q[cur];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i] <= '0;
        pri_q[i] <= MASKED;
      end
      asrt_q     <= '0;
      sent_q     <= '0;
      rej_q      <= '0;
      mpend_q    <= '0;
      scan_q     <= 1'b0;
      scan_idx   <= '0;
      req_valid  <= 1'b0;
      req_num    <= '0;
      req_server <= '0;
      req_prio   <= '0;
    end else begin
      if (req_valid && req_ack) req_valid <= 1'b0;
      if (fire) begin
        req_valid  <= 1'b1;
        req_num    <= NUMW'(cur) + NUMW'(BASE);
        req_server <= f_srv;
        req_prio   <= f_pri;
      end
      if (scan_step) begin
        if (cur_lvl) begin
          if (fire) sent_q[cur] <= 1'b1;
        end else begin
          rej_q[cur] <= 1'b0;
        end
        if (scan_idx == IW'(NSRC - 1)) scan_q <= 1'b0;
        else                           scan_idx <= scan_idx + 1'b1;
      end else if (take) begin
        if (cmd_op == OP_RESEND) begin
          scan_q   <= 1'b1;
          scan_idx <= '0;
        end else if (in_rng) begin
          case (cmd_op)
            OP_EVENT: begin
              if (cur_lvl) begin
                asrt_q[cur] <= cmd_val;
                if (fire) sent_q[cur] <= 1'b1;
              end else if (cmd_val && !unmasked) begin
                mpend_q[cur] <= 1'b1;
              end
            end
            OP_WRITE: begin
              srv_q[cur] <= cmd_server;
              pri_q[cur] <= cmd_prio;
              if (fire) begin
                if (cur_lvl) sent_q[cur]  <= 1'b1;
                else         mpend_q[cur] <= 1'b0;
              end
            end
            OP_REJECT: begin
              if (cur_lvl) sent_q[cur] <= 1'b0;
              else         rej_q[cur]  <= 1'b1;
            end
            OP_EOI: begin
              if (cur_lvl) sent_q[cur] <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_source_ctl_chk.sv
module irq_source_ctl_chk #(
  parameter int NSRC = 8,
  parameter int BASE = 16,
  parameter int NUMW = 8,
  parameter int SRVW = 4,
  parameter int PRIW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic            req_valid,
  input logic            req_ack,
  input logic [NUMW-1:0] req_num,
  input logic [SRVW-1:0] req_server,
  input logic [PRIW-1:0] req_prio
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_num) && $stable(req_server) && $stable(req_prio)));

  assert_drop_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> !req_valid);

  assert_stall_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);

  assert_resend_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd4) |=> !cmd_ready);

  assert_never_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_prio != {PRIW{1'b1}}));

  assert_num_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_num >= NUMW'(BASE) && req_num < NUMW'(BASE + NSRC)));
endmodule

bind irq_source_ctl irq_source_ctl_chk #(
  .NSRC(NSRC), .BASE(BASE), .NUMW(NUMW), .SRVW(SRVW), .PRIW(PRIW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .req_valid(req_valid), .req_ack(req_ack), .req_num(req_num),
  .req_server(req_server), .req_prio(req_prio)
);

// File: tb/irq_source_ctl_test.sv
module irq_source_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_num = '0;
  logic       cmd_val = 1'b0;
  logic [3:0] cmd_server = '0;
  logic [7:0] cmd_prio = '0;
  logic       req_valid;
  logic       req_ack = 1'b0;
  logic [7:0] req_num;
  logic [3:0] req_server;
  logic [7:0] req_prio;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irq_source_ctl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_num(cmd_num), .cmd_val(cmd_val), .cmd_server(cmd_server),
    .cmd_prio(cmd_prio), .req_valid(req_valid), .req_ack(req_ack), .req_num(req_num),
    .req_server(req_server), .req_prio(req_prio)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // op, num, val, srv, prio, exp_valid, exp_num, exp_srv, exp_prio, requirement
  localparam int NV = 16;
  localparam logic [48:0] VEC [NV] = '{
    {3'd1, 8'd16, 1'b0, 4'd3, 8'd5,   1'b0, 8'd0,  4'd0, 8'd0, 4'd2},  // R2 configure
    {3'd0, 8'd16, 1'b1, 4'd0, 8'd0,   1'b1, 8'd16, 4'd3, 8'd5, 4'd2},  // R2 message event
    {3'd0, 8'd17, 1'b1, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd3},  // R3 masked event
    {3'd1, 8'd17, 1'b0, 4'd2, 8'd7,   1'b1, 8'd17, 4'd2, 8'd7, 4'd3},  // R3 release
    {3'd1, 8'd17, 1'b0, 4'd2, 8'd7,   1'b0, 8'd0,  4'd0, 8'd0, 4'd3},  // R3 once only
    {3'd0, 8'd20, 1'b1, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd4},  // R4 masked level
    {3'd1, 8'd20, 1'b0, 4'd1, 8'd3,   1'b1, 8'd20, 4'd1, 8'd3, 4'd7},  // R7 write presents
    {3'd0, 8'd20, 1'b1, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd4},  // R4 already sent
    {3'd3, 8'd20, 1'b0, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd6},  // R6 level EOI
    {3'd0, 8'd20, 1'b1, 4'd0, 8'd0,   1'b1, 8'd20, 4'd1, 8'd3, 4'd6},  // R6 re-present
    {3'd0, 8'd20, 1'b0, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd4},  // R4 deassert
    {3'd2, 8'd20, 1'b0, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd5},  // R5 level reject
    {3'd0, 8'd15, 1'b1, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd9},  // R9 below range
    {3'd0, 8'd24, 1'b1, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd9},  // R9 above range
    {3'd1, 8'd21, 1'b0, 4'd4, 8'hFF,  1'b0, 8'd0,  4'd0, 8'd0, 4'd11}, // R11 masked write
    {3'd0, 8'd21, 1'b1, 4'd0, 8'd0,   1'b0, 8'd0,  4'd0, 8'd0, 4'd11}  // R11 masked level
  };

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] num, input logic val,
                        input logic [3:0] srv, input logic [7:0] prio);
    int w = 0;
    @(negedge clk);
    while (!cmd_ready && w < 100) begin
      @(negedge clk);
      w++;
    end
    cmd_valid = 1'b1; cmd_op = op; cmd_num = num; cmd_val = val;
    cmd_server = srv; cmd_prio = prio;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ack_req;
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
  endtask

  task automatic expect_req(input logic ev, input logic [7:0] n, input logic [3:0] s,
                            input logic [7:0] p, input string tag);
    if (!ev) begin
      check(!req_valid, tag, $sformatf("valid=%0b", req_valid), "valid=0");
      if (req_valid) ack_req();
    end else begin
      check(req_valid && req_num == n && req_server == s && req_prio == p, tag,
            $sformatf("v=%0b n=%0d s=%0d p=%0d", req_valid, req_num, req_server, req_prio),
            $sformatf("v=1 n=%0d s=%0d p=%0d", n, s, p));
      if (req_valid) ack_req();
    end
  endtask

  task automatic wait_req(input logic [7:0] n, input logic [3:0] s, input logic [7:0] p,
                          input string tag);
    int w = 0;
    while (!req_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    expect_req(1'b1, n, s, p, tag);
  endtask

  task automatic expect_quiet(input int ncyc, input string tag);
    bit seen = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    check(!seen && cmd_ready, tag, $sformatf("seen=%0b ready=%0b", seen, cmd_ready),
          "seen=0 ready=1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid && cmd_ready, "R1 reset", $sformatf("v=%0b r=%0b", req_valid, cmd_ready), "v=0 r=1");

    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i][48:46], VEC[i][45:38], VEC[i][37], VEC[i][36:33], VEC[i][32:25]);
      expect_req(VEC[i][24], VEC[i][23:16], VEC[i][15:12], VEC[i][11:4],
                 $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R5 and R8: build rejected sources, then resend
    do_cmd(3'd0, 8'd16, 1'b1, 4'd0, 8'd0); expect_req(1'b1, 8'd16, 4'd3, 8'd5, "R2 setup16");
    do_cmd(3'd2, 8'd16, 1'b0, 4'd0, 8'd0);
    do_cmd(3'd0, 8'd17, 1'b1, 4'd0, 8'd0); expect_req(1'b1, 8'd17, 4'd2, 8'd7, "R2 setup17");
    do_cmd(3'd2, 8'd17, 1'b0, 4'd0, 8'd0);
    do_cmd(3'd0, 8'd20, 1'b1, 4'd0, 8'd0); expect_req(1'b1, 8'd20, 4'd1, 8'd3, "R4 setup20");
    do_cmd(3'd2, 8'd20, 1'b0, 4'd0, 8'd0);
    do_cmd(3'd3, 8'd16, 1'b0, 4'd0, 8'd0); // R6 EOI on message source has no effect
    do_cmd(3'd4, 8'd0, 1'b0, 4'd0, 8'd0);
    check(!cmd_ready, "R8 busy in scan", $sformatf("ready=%0b", cmd_ready), "ready=0");
    begin
      int w = 0;
      while (!req_valid && w < 20) begin @(negedge clk); w++; end
    end
    @(negedge clk);
    check(req_valid && req_num == 8'd16, "R10 held", $sformatf("v=%0b n=%0d", req_valid, req_num), "v=1 n=16");
    @(negedge clk);
    check(!cmd_ready && req_num == 8'd16, "R8 stall pending", $sformatf("r=%0b n=%0d", cmd_ready, req_num), "r=0 n=16");
    expect_req(1'b1, 8'd16, 4'd3, 8'd5, "R6 msg EOI ignored, R5 resend16");
    wait_req(8'd17, 4'd2, 8'd7, "R5 resend17");
    wait_req(8'd20, 4'd1, 8'd3, "R5 resend level20");
    expect_quiet(12, "R8 scan ends");

    do_cmd(3'd4, 8'd0, 1'b0, 4'd0, 8'd0);
    expect_quiet(12, "R8 second resend empty");

    do_cmd(3'd3, 8'd20, 1'b0, 4'd0, 8'd0);
    do_cmd(3'd4, 8'd0, 1'b0, 4'd0, 8'd0);
    wait_req(8'd20, 4'd1, 8'd3, "R6 level EOI resend");
    expect_quiet(12, "R6 only level20");

    // R1: reset clears state but keeps type
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid && cmd_ready, "R1 reset again", $sformatf("v=%0b r=%0b", req_valid, cmd_ready), "v=0 r=1");
    do_cmd(3'd0, 8'd16, 1'b1, 4'd0, 8'd0); expect_req(1'b0, 8'd0, 4'd0, 8'd0, "R1 masked after reset");
    do_cmd(3'd4, 8'd0, 1'b0, 4'd0, 8'd0);
    expect_quiet(12, "R1 rejected cleared");
    do_cmd(3'd0, 8'd20, 1'b1, 4'd0, 8'd0);
    do_cmd(3'd0, 8'd20, 1'b0, 4'd0, 8'd0);
    do_cmd(3'd1, 8'd20, 1'b0, 4'd1, 8'd3); expect_req(1'b0, 8'd0, 4'd0, 8'd0, "R1 level type kept");
    do_cmd(3'd1, 8'd16, 1'b0, 4'd6, 8'd9); expect_req(1'b1, 8'd16, 4'd6, 8'd9, "R3 pending after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule